// File: doc/BRIEF.md
# Inbound Address Decode Window Unit

This block decides where an inbound bus request lands inside the chip. Software programs a set of decode windows through a write-only register port. Each window has a control word, a base and a remap value. Every request is first checked against an aperture. The aperture is a single power-of-two region, with its own enable, that decides whether the request is claimed at all. After that, the request is compared against all enabled windows in parallel.

On a hit, the block returns the window's target ID and attribute byte, together with the address as seen by the target. In that address, the bits inside the window keep their offset and the bits above the window come from the remap register. On a miss, it flags a decode error and returns no target. The response is registered and appears one clock after the request.

Register offsets (byte addresses on `wr_addr`):
- General window n (n = 0..4): control at 16·n, base at 16·n+4, remap at 16·n+0xC.
- Sixth window: control at 0x80, base at 0x84, remap at 0x8C.
- Aperture: control at 0xA0, low base at 0xA4, high base at 0xA8.

Top module: `adw_unit`

## Requirements
- R1: After synchronous reset, every window and the aperture are disabled and all response outputs are zero, so any request returns a miss.
- R2: A window control write stores the encoded size minus one (in 64 KiB units) from bits 31:16, the attribute from bits 15:8, the target ID from bits 7:4 and the enable from bit 0. An enabled window hits when `(addr[31:16] & ~size) == (base[31:16] & ~size)`.
- R3: A window whose enable bit is 0 never produces a hit, even when its base matches the address.
- R4: Only bits 31:16 of a base or remap write are kept; bits 15:0 of the written word have no effect on decoding or on the output address.
- R5: On a hit, `rsp_target` carries control bits 7:4, `rsp_attr` carries control bits 15:8, and `rsp_win` carries the index of the window that hit (0..4 general, 5 for the sixth window).
- R6: On a hit, `rsp_addr[15:0]` equals `req_addr[15:0]`. Each bit of `rsp_addr[31:16]` comes from the request where the size field bit is 1, and from the remap register where it is 0.
- R7: When several enabled windows match, the lowest-numbered one wins.
- R8: A request is claimed only if the aperture is enabled (control bit 0), `req_addr[63:32]` equals the high base, and `req_addr[31:16]` matches the low base bits 31:16 outside the aperture size field (control bits 31:16). Otherwise the request misses whatever the windows hold.
- R9: On a miss, `rsp_miss` is 1 and `rsp_hit`, `rsp_win`, `rsp_target`, `rsp_attr` and `rsp_addr` are all zero.
- R10: A response (`rsp_valid` = 1, with exactly one of `rsp_hit` or `rsp_miss`) appears exactly one cycle after each cycle with `req_valid` = 1. In other cycles all response outputs are zero.
- R11: The sixth window, programmed at offsets 0x80, 0x84 and 0x8C, decodes exactly like a general window and ranks below all five general windows.
- R12: A request in the same cycle as a register write is decoded with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Inbound request present |
| req_addr | input | 64 | Inbound request address |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Request decoded to a window |
| rsp_miss | output | 1 | Decode error |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The assertions check, on every cycle, the properties that need no knowledge of the programmed windows:
- the one-cycle request-to-response timing and the zero idle outputs;
- that hit and miss are exclusive;
- that a miss carries all-zero fields;
- that the low 16 address bits pass through on a hit.

Only the bench scenarios can show the rest. This covers the field decoding of the control word, the masking of low base bits, remap substitution, lowest-index priority among overlapping windows, aperture gating including the upper address word, and the ordering between a write and a request in the same cycle. For these, the bench compares every cycle against its behavioural model.

// File: rtl/adw_pkg.sv
package adw_pkg;
  typedef struct packed {
    logic        en;
    logic [15:0] size;
    logic [7:0]  attr;
    logic [3:0]  tgt;
    logic [15:0] base;
    logic [15:0] remap;
  } adw_win_t;

  typedef struct packed {
    logic        en;
    logic [15:0] size;
    logic [15:0] base_lo;
    logic [31:0] base_hi;
  } adw_ap_t;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_BASE  = 4;
  localparam int OFS_REMAP = 12;
  localparam int WIN_STRIDE = 16;
endpackage

// File: rtl/adw_regs.sv
module adw_regs
  import adw_pkg::*;
#(
  parameter int N_GEN     = 5,
  parameter int REG_AW    = 8,
  parameter int EXTRA_OFS = 'h80,
  parameter int AP_OFS    = 'hA0,
  localparam int NWIN     = N_GEN + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output adw_win_t          win [NWIN],
  output adw_ap_t           ap
);
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int WOFS = (g < N_GEN) ? g * WIN_STRIDE : EXTRA_OFS;
    always_ff @(posedge clk) begin
      if (rst) begin
        win[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == REG_AW'(WOFS + OFS_CTRL)) begin
          win[g].en   <= wr_data[0];
          win[g].tgt  <= wr_data[7:4];
          win[g].attr <= wr_data[15:8];
          win[g].size <= wr_data[31:16];
        end
        if (wr_addr == REG_AW'(WOFS + OFS_BASE))
          win[g].base <= wr_data[31:16];
        if (wr_addr == REG_AW'(WOFS + OFS_REMAP))
          win[g].remap <= wr_data[31:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ap <= '0;
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(AP_OFS)) begin
        ap.en   <= wr_data[0];
        ap.size <= wr_data[31:16];
      end
      if (wr_addr == REG_AW'(AP_OFS + 4))
        ap.base_lo <= wr_data[31:16];
      if (wr_addr == REG_AW'(AP_OFS + 8))
        ap.base_hi <= wr_data;
    end
  end
endmodule

// File: rtl/adw_match.sv
module adw_match
  import adw_pkg::*;
#(
  parameter int NWIN = 6
) (
  input  adw_win_t    win [NWIN],
  input  adw_ap_t     ap,
  input  logic [63:0] addr,
  output logic        ap_hit,
  output logic [NWIN-1:0] win_hit
);
  always_comb begin
    ap_hit = ap.en && (addr[63:32] == ap.base_hi) &&
             (((addr[31:16] ^ ap.base_lo) & ~ap.size) == 16'h0);
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign win_hit[g] = win[g].en &&
                        (((addr[31:16] ^ win[g].base) & ~win[g].size) == 16'h0);
  end
endmodule

// File: rtl/adw_prio.sv
module adw_prio #(
  parameter int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/adw_unit.sv
module adw_unit
  import adw_pkg::*;
#(
  parameter int N_GEN     = 5,
  parameter int REG_AW    = 8,
  parameter int EXTRA_OFS = 'h80,
  parameter int AP_OFS    = 'hA0,
  localparam int NWIN     = N_GEN + 1,
  localparam int IW       = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IW-1:0]     rsp_win,
  output logic [3:0]        rsp_target,
  output logic [7:0]        rsp_attr,
  output logic [31:0]       rsp_addr
);
  adw_win_t        win [NWIN];
  adw_ap_t         ap;
  logic            ap_hit;
  logic [NWIN-1:0] win_hit;
  logic            found;
  logic [IW-1:0]   idx;
  adw_win_t        sel;
  logic            claim;
  logic [15:0]     up;

  adw_regs #(.N_GEN(N_GEN), .REG_AW(REG_AW), .EXTRA_OFS(EXTRA_OFS), .AP_OFS(AP_OFS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win(win), .ap(ap)
  );

  adw_match #(.NWIN(NWIN)) u_match (
    .win(win), .ap(ap), .addr(req_addr), .ap_hit(ap_hit), .win_hit(win_hit)
  );

  adw_prio #(.N(NWIN)) u_prio (.req(win_hit), .found(found), .idx(idx));

  always_comb begin
    sel   = win[idx];
    claim = ap_hit && found;
    up    = (req_addr[31:16] & sel.size) | (sel.remap & ~sel.size);
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= claim;
      rsp_miss   <= !claim;
      rsp_win    <= claim ? idx : '0;
      rsp_target <= claim ? sel.tgt : 4'h0;
      rsp_attr   <= claim ? sel.attr : 8'h0;
      rsp_addr   <= claim ? {up, req_addr[15:0]} : 32'h0;
    end
  end
endmodule

// File: rtl/adw_unit_chk.sv
module adw_unit_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [63:0]   req_addr,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_miss,
  input logic [IW-1:0] rsp_win,
  input logic [3:0]    rsp_target,
  input logic [7:0]    rsp_attr,
  input logic [31:0]   rsp_addr
);
  p_req_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_one_kind_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss}) == 1));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_addr == 32'h0));

  p_miss_clean_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_win == '0 && rsp_target == 4'h0 && rsp_attr == 8'h0 && rsp_addr == 32'h0));

  p_low_pass_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_addr[15:0] == $past(req_addr[15:0])));
endmodule

bind adw_unit adw_unit_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
  .rsp_target(rsp_target), .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
);

// File: tb/sim_adw_unit.sv
module sim_adw_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  adw_unit u0 (.*);

  // behavioural model state
  logic        m_en [6];
  logic [15:0] m_size [6], m_base [6], m_remap [6];
  logic [7:0]  m_attr [6];
  logic [3:0]  m_tgt [6];
  logic        a_en;
  logic [15:0] a_size, a_lo;
  logic [31:0] a_hi;
  logic        e_valid, e_hit, e_miss;
  logic [2:0]  e_win;
  logic [3:0]  e_tgt;
  logic [7:0]  e_attr;
  logic [31:0] e_addr;

  always @(posedge clk) begin
    int w, k;
    e_valid = 0; e_hit = 0; e_miss = 0; e_win = 0; e_tgt = 0; e_attr = 0; e_addr = 0;
    if (rst) begin
      for (int i = 0; i < 6; i++) begin
        m_en[i] = 0; m_size[i] = 0; m_base[i] = 0; m_remap[i] = 0; m_attr[i] = 0; m_tgt[i] = 0;
      end
      a_en = 0; a_size = 0; a_lo = 0; a_hi = 0;
    end else begin
      if (req_valid) begin
        e_valid = 1;
        e_miss = 1;
        if (a_en && req_addr[63:32] == a_hi &&
            ((req_addr[31:16] & ~a_size) == (a_lo & ~a_size))) begin
          for (int i = 0; i < 6; i++) begin
            if (e_miss && m_en[i] &&
                ((req_addr[31:16] & ~m_size[i]) == (m_base[i] & ~m_size[i]))) begin
              e_miss = 0; e_hit = 1; e_win = 3'(i); e_tgt = m_tgt[i]; e_attr = m_attr[i];
              e_addr = {(req_addr[31:16] & m_size[i]) | (m_remap[i] & ~m_size[i]),
                        req_addr[15:0]};
            end
          end
        end
      end
      if (wr_en) begin
        w = -1; k = 0;
        if (wr_addr < 8'h50) begin w = wr_addr / 16; k = wr_addr % 16; end
        else if (wr_addr >= 8'h80 && wr_addr < 8'h90) begin w = 5; k = wr_addr - 8'h80; end
        if (w >= 0) begin
          if (k == 0) begin
            m_en[w] = wr_data[0]; m_tgt[w] = wr_data[7:4];
            m_attr[w] = wr_data[15:8]; m_size[w] = wr_data[31:16];
          end
          if (k == 4)  m_base[w] = wr_data[31:16];
          if (k == 12) m_remap[w] = wr_data[31:16];
        end
        if (wr_addr == 8'hA0) begin a_en = wr_data[0]; a_size = wr_data[31:16]; end
        if (wr_addr == 8'hA4) a_lo = wr_data[31:16];
        if (wr_addr == 8'hA8) a_hi = wr_data;
      end
    end
  end

  task automatic compare();
    total++;
    if ({rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr, rsp_addr} !==
        {e_valid, e_hit, e_miss, e_win, e_tgt, e_attr, e_addr}) begin
      bad++;
      $display("FAIL %s: got v=%0b h=%0b m=%0b w=%0d t=%h a=%h addr=%h exp v=%0b h=%0b m=%0b w=%0d t=%h a=%h addr=%h",
               tag, rsp_valid, rsp_hit, rsp_miss, rsp_win, rsp_target, rsp_attr, rsp_addr,
               e_valid, e_hit, e_miss, e_win, e_tgt, e_attr, e_addr);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                     input logic rv, input logic [63:0] ra);
    @(negedge clk);
    compare();
    wr_en = we; wr_addr = wa; wr_data = wd; req_valid = rv; req_addr = ra;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 64'h0);
  endtask

  task automatic rq(input logic [63:0] a);
    cyc(1'b0, 8'h0, 32'h0, 1'b1, a);
  endtask

  task automatic idle();
    cyc(1'b0, 8'h0, 32'h0, 1'b0, 64'h0);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare();                     // R1 reset state
    rst = 1'b0;
    tag = "R1"; idle(); rq(64'h0); rq(64'h1000_0000); idle();

    tag = "R8"; // window 0 programmed, aperture still off
    wr(8'h00, 32'h0000_E031); wr(8'h04, 32'h1000_0000);
    rq(64'h1000_1234); idle();
    wr(8'hA8, 32'h0); wr(8'hA4, 32'h0); wr(8'hA0, 32'hFFFF_0001);
    rq(64'h1000_1234); rq(64'h0000_0001_1000_1234); idle();
    wr(8'hA0, 32'h0FFF_0001); rq(64'h1000_1234); idle();   // aperture too small
    wr(8'hA8, 32'h0000_0002); wr(8'hA0, 32'hFFFF_0001);
    rq(64'h0000_0002_1000_0010); rq(64'h1000_0010); idle();
    wr(8'hA8, 32'h0);

    tag = "R5"; rq(64'h1000_FFFF); rq(64'h1001_0000); idle();
    tag = "R3"; wr(8'h10, 32'h0000_7750); wr(8'h14, 32'h2000_0000);
    rq(64'h2000_0004); idle();
    tag = "R4"; wr(8'h10, 32'h0000_7751); wr(8'h14, 32'h2000_ABCD); wr(8'h1C, 32'h3000_5555);
    rq(64'h2000_0004); rq(64'h2000_ABCC); idle();
    tag = "R6"; wr(8'h20, 32'h000F_0121); wr(8'h24, 32'h4000_0000); wr(8'h2C, 32'h8000_0000);
    rq(64'h4005_1234); rq(64'h400F_FFFF); rq(64'h4010_0000); idle();
    tag = "R7"; wr(8'h30, 32'h00FF_0231); wr(8'h34, 32'h5000_0000);
    wr(8'h40, 32'h0000_0341); wr(8'h44, 32'h5030_0000);
    rq(64'h5030_0008); wr(8'h30, 32'h00FF_0230); rq(64'h5030_0008); idle();
    tag = "R11"; wr(8'h80, 32'h0003_4451); wr(8'h84, 32'h6000_0000); wr(8'h8C, 32'h7000_0000);
    rq(64'h6002_0100); wr(8'h44, 32'h6000_0000); rq(64'h6000_0100); idle();
    tag = "R9"; rq(64'h9000_0000); rq(64'hF000_0000); idle();
    tag = "R12"; cyc(1'b1, 8'h40, 32'h0, 1'b1, 64'h6000_0100); rq(64'h6000_0100); idle();
    tag = "R2";
    for (int n = 0; n < 300; n++) begin
      if (n % 7 == 3) wr(8'((n % 5) * 16), {16'((n * 37) & 16'h00FF), 8'(n), 4'(n), 3'b0, 1'(n % 3 != 0)});
      else if (n % 7 == 5) wr(8'((n % 5) * 16 + 4), {16'(n * 4099), 16'hFFFF});
      else rq({32'h0, 16'(n * 4099 + (n % 3)), 16'(n * 13)});
    end
    tag = "R10"; rq(64'h1000_0000); idle(); idle();
    tag = "R1"; rst = 1'b1; idle(); idle(); rst = 1'b0; rq(64'h1000_0000); idle();
    finish_run();
  end
endmodule